// File: doc/BRIEF.md
# One-Time-Set Decrement-Only Usage Counter

This block keeps a usage count that can be loaded a single time and afterwards only counts down, stopping permanently at zero. It is meant for products that grant a limited number of uses: a host loads the allowance once, issues a decrement for each use and reads the remaining count back. Before the first load the stored value is meaningless. A read in that state returns bits taken from a pseudo-random input, and the read is flagged as not fit for authentication.

Three single-cycle request strobes drive the block: load, decrement and read. When several arrive together, the load wins, then the decrement, then the read. Only the winner acts. Every accepted request leaves a two-bit result code one cycle later, and that code holds until the next request. A read also updates the read data and the authentication-permitted flag, which hold until the next read. All pins are plain control and status signals. The strobes are always accepted, so there is no back-pressure.

Top module: `usage_counter`

## Requirements
- R1: After reset, `loaded` is 0, `result` is 2'b00, `rd_count` is 0 and `rd_auth_ok` is 0.
- R2: A load request while `loaded` is 0 stores `load_value` and sets `loaded` to 1 one cycle later, with result 2'b00 (done). `loaded` never clears again until reset.
- R3: A load request while `loaded` is 1 gives result 2'b01 (locked) and leaves the stored count unchanged.
- R4: A read request while `loaded` is 0 gives result 2'b10 (blank). `rd_count` then equals the `rnd_bits` value of the request cycle, and `rd_auth_ok` is 0. A read while `loaded` is 1 gives result 2'b00, `rd_count` equal to the stored count, and `rd_auth_ok` 1.
- R5: A decrement request while loaded with a non-zero count lowers the count by exactly one, with result 2'b00.
- R6: A decrement request while loaded with a count of zero gives result 2'b11 (exhausted) and the count stays zero.
- R7: A decrement request while `loaded` is 0 gives result 2'b10 (blank) and `loaded` stays 0.
- R8: When several request strobes are high in one cycle, only the highest-priority one acts (load over decrement, decrement over read). The others have no effect on the count, `result`, `rd_count` or `rd_auth_ok`.
- R9: `result` changes only in the cycle after a request. `rd_count` and `rd_auth_ok` change only in the cycle after a read that wins arbitration.
- R10: Once loaded, the stored count never increases, whatever requests arrive. The count is 17 bits wide by default, and the full range up to 17'h1FFFF is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_req | input | 1 | One-cycle strobe: load the count once |
| load_value | input | 17 | Count value used by a load request |
| dec_req | input | 1 | One-cycle strobe: lower the count by one |
| rd_req | input | 1 | One-cycle strobe: read the count |
| rnd_bits | input | 17 | Pseudo-random bits returned by reads before loading |
| loaded | output | 1 | High once the count has been loaded |
| result | output | 2 | Result code of the last request: 00 done, 01 locked, 10 blank, 11 exhausted |
| rd_count | output | 17 | Data from the last read |
| rd_auth_ok | output | 1 | Last read may be authenticated (count was loaded) |

## Verification
A wrong loaded flag shows on the first request after the fault: `result` reads blank where it should read done or locked, and `rd_auth_ok` disagrees on the next read. A wrong count is hidden until a read, so the directed scenarios read the count back one cycle after each load, decrement or rejected command. A wrong priority order shows as a result code, or a read-data change, that belongs to the losing strobe. A floor fault shows on the first decrement issued at zero.

// File: rtl/uc_pkg.sv
package uc_pkg;
  typedef enum logic [1:0] {
    RES_DONE      = 2'b00,
    RES_LOCKED    = 2'b01,
    RES_BLANK     = 2'b10,
    RES_EXHAUSTED = 2'b11
  } uc_result_e;
endpackage

// File: rtl/uc_arbiter.sv
module uc_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic load_req,
  input  logic dec_req,
  input  logic rd_req,
  output logic g_load,
  output logic g_dec,
  output logic g_rd
);
  // fixed priority: load, then decrement, then read
  always_comb begin
    g_load = load_req;
    g_dec  = dec_req & ~load_req;
    g_rd   = rd_req & ~load_req & ~dec_req;
  end

  p_single_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({g_load, g_dec, g_rd}));
  p_grant_when_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req | dec_req | rd_req) |-> (g_load | g_dec | g_rd));
endmodule

// File: rtl/uc_count_core.sv
module uc_count_core #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          g_load,
  input  logic          g_dec,
  input  logic [CW-1:0] load_value,
  output logic [CW-1:0] count,
  output logic          loaded,
  output logic          at_zero
);
  localparam logic [CW-1:0] ONE = CW'(1);

  assign at_zero = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      loaded <= 1'b0;
    end else if (g_load) begin
      if (!loaded) begin
        count  <= load_value;
        loaded <= 1'b1;
      end
    end else if (g_dec && loaded && !at_zero) begin
      count <= count - ONE;
    end
  end

  p_loaded_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> loaded);
  p_no_increase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> (count <= $past(count)));
  p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (g_dec && loaded && !at_zero) |=> (count == $past(count) - ONE));
  p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && at_zero) |=> at_zero);
  p_blank_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (g_dec && !loaded) |=> !loaded);
endmodule

// File: rtl/uc_resp_reg.sv
module uc_resp_reg
  import uc_pkg::*;
#(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          g_load,
  input  logic          g_dec,
  input  logic          g_rd,
  input  logic          loaded,
  input  logic          at_zero,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] rnd_bits,
  output uc_result_e    result,
  output logic [CW-1:0] rd_count,
  output logic          rd_auth_ok
);
  uc_result_e res_next;

  always_comb begin
    res_next = result;
    if (g_load)     res_next = loaded ? RES_LOCKED : RES_DONE;
    else if (g_dec) res_next = !loaded ? RES_BLANK
                              : (at_zero ? RES_EXHAUSTED : RES_DONE);
    else if (g_rd)  res_next = loaded ? RES_DONE : RES_BLANK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= RES_DONE;
      rd_count   <= '0;
      rd_auth_ok <= 1'b0;
    end else begin
      result <= res_next;
      if (g_rd) begin
        rd_count   <= loaded ? count : rnd_bits;
        rd_auth_ok <= loaded;
      end
    end
  end

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(g_load | g_dec | g_rd) |=> $stable(result));
  p_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !g_rd |=> ($stable(rd_count) && $stable(rd_auth_ok)));
  p_blank_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (g_rd && !loaded) |=> (!rd_auth_ok && result == RES_BLANK));
endmodule

// File: rtl/usage_counter.sv
module usage_counter
  import uc_pkg::*;
#(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_req,
  input  logic [CW-1:0] load_value,
  input  logic          dec_req,
  input  logic          rd_req,
  input  logic [CW-1:0] rnd_bits,
  output logic          loaded,
  output logic [1:0]    result,
  output logic [CW-1:0] rd_count,
  output logic          rd_auth_ok
);
  logic g_load, g_dec, g_rd, at_zero;
  logic [CW-1:0] count;
  uc_result_e res_e;

  uc_arbiter u_arb (
    .clk(clk), .rst_n(rst_n),
    .load_req(load_req), .dec_req(dec_req), .rd_req(rd_req),
    .g_load(g_load), .g_dec(g_dec), .g_rd(g_rd)
  );

  uc_count_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n),
    .g_load(g_load), .g_dec(g_dec), .load_value(load_value),
    .count(count), .loaded(loaded), .at_zero(at_zero)
  );

  uc_resp_reg #(.CW(CW)) u_resp (
    .clk(clk), .rst_n(rst_n),
    .g_load(g_load), .g_dec(g_dec), .g_rd(g_rd),
    .loaded(loaded), .at_zero(at_zero), .count(count), .rnd_bits(rnd_bits),
    .result(res_e), .rd_count(rd_count), .rd_auth_ok(rd_auth_ok)
  );

  assign result = res_e;

  p_locked_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && loaded) |=> (result == 2'b01 && $stable(loaded)));
endmodule

// File: tb/tb_usage_counter.sv
module tb_usage_counter;
  localparam int CW = 17;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_req = 1'b0, dec_req = 1'b0, rd_req = 1'b0;
  logic [CW-1:0] load_value = '0, rnd_bits = '0;
  logic loaded, rd_auth_ok;
  logic [1:0] result;
  logic [CW-1:0] rd_count;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  usage_counter #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .load_value(load_value),
    .dec_req(dec_req), .rd_req(rd_req), .rnd_bits(rnd_bits),
    .loaded(loaded), .result(result), .rd_count(rd_count), .rd_auth_ok(rd_auth_ok)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive strobes for one cycle; after return the edge has been taken
  task automatic req(logic l, logic d, logic r, logic [CW-1:0] v, logic [CW-1:0] rb);
    @(negedge clk);
    load_req = l; dec_req = d; rd_req = r; load_value = v; rnd_bits = rb;
    @(negedge clk);
    load_req = 0; dec_req = 0; rd_req = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 loaded", loaded, 0);
    chk("R1 result", result, 2'b00);
    chk("R1 rd_count", rd_count, 0);
    chk("R1 rd_auth_ok", rd_auth_ok, 0);
  endtask

  task automatic t_blank();
    req(0, 0, 1, 0, 17'h0ABCD);
    chk("R4 blank read data", rd_count, 17'h0ABCD);
    chk("R4 blank read auth", rd_auth_ok, 0);
    chk("R4 blank read result", result, 2'b10);
    req(0, 1, 0, 0, 17'h15555);
    chk("R7 blank dec result", result, 2'b10);
    chk("R7 blank dec loaded", loaded, 0);
    req(0, 0, 1, 0, 17'h1F00F);
    chk("R4 second blank read", rd_count, 17'h1F00F);
  endtask

  task automatic t_load();
    req(1, 0, 0, 17'd5, 0);
    chk("R2 loaded", loaded, 1);
    chk("R2 result", result, 2'b00);
    req(0, 0, 1, 0, 17'h12345);
    chk("R4 loaded read data", rd_count, 5);
    chk("R4 loaded read auth", rd_auth_ok, 1);
    chk("R4 loaded read result", result, 2'b00);
  endtask

  task automatic t_reload();
    req(1, 0, 0, 17'h1FFFF, 0);
    chk("R3 reload result", result, 2'b01);
    req(0, 0, 1, 0, 0);
    chk("R3 R10 count kept after larger reload", rd_count, 5);
  endtask

  task automatic t_dec();
    req(0, 1, 0, 0, 0);
    chk("R5 dec result", result, 2'b00);
    req(0, 0, 1, 0, 0);
    chk("R5 count after dec", rd_count, 4);
    req(1, 0, 0, 17'd9, 0);
    chk("R3 locked before idle", result, 2'b01);
    repeat (3) @(negedge clk);
    chk("R9 result held while idle", result, 2'b01);
    chk("R9 rd_count held while idle", rd_count, 4);
  endtask

  task automatic t_priority();
    req(1, 1, 1, 17'd20, 0);
    chk("R8 load wins result", result, 2'b01);
    chk("R8 read ignored under load", rd_count, 4);
    req(0, 0, 1, 0, 0);
    chk("R8 dec ignored under load", rd_count, 4);
    req(0, 1, 1, 0, 0);
    chk("R8 dec wins result", result, 2'b00);
    chk("R8 R9 read ignored under dec", rd_count, 4);
    req(0, 0, 1, 0, 0);
    chk("R8 dec acted", rd_count, 3);
  endtask

  task automatic t_exhaust();
    repeat (3) req(0, 1, 0, 0, 0);
    req(0, 0, 1, 0, 0);
    chk("R5 reached zero", rd_count, 0);
    req(0, 1, 0, 0, 0);
    chk("R6 exhausted result", result, 2'b11);
    req(0, 0, 1, 0, 17'h1AAAA);
    chk("R6 count stays zero", rd_count, 0);
    chk("R6 read at zero result", result, 2'b00);
  endtask

  task automatic t_full_range();
    do_reset();
    req(1, 0, 0, 17'h1FFFF, 0);
    req(0, 0, 1, 0, 0);
    chk("R10 full range load", rd_count, 17'h1FFFF);
    req(0, 1, 0, 0, 0);
    req(0, 0, 1, 0, 0);
    chk("R10 R5 full range dec", rd_count, 17'h1FFFE);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_blank();
    t_load();
    t_reload();
    t_dec();
    t_priority();
    t_exhaust();
    t_full_range();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule